// File: doc/BRIEF.md
# Serial Two-Wire Memory Target

This block lets a two-wire serial bus controller read and write a small byte-addressed memory. The memory holds a register window and a user SRAM window. The block watches the already-synchronised clock and data lines and recognises its 7-bit device code. It takes in a word address, which loads an internal pointer that persists between transactions. It then stores one data byte, or returns one byte from the pointer. The data line is driven open-drain: the block only ever pulls it low.

Behind the bus side the block presents a plain synchronous memory port. The port carries an address equal to the pointer, write data, a one-cycle write enable, and read data that the memory returns one clock after the address. Two kinds of read are supported. A current-address read uses the pointer left by the previous access. A random read first sets the pointer with an address-only write, then uses a repeated start. A word address outside both windows is refused with a not-acknowledge.

Top module: `i2c_memtarget`

## Requirements
- R1: A control byte whose upper seven bits equal 1101111 is acknowledged, and its last bit selects write (0) or read (1). Any other control byte gets no acknowledge, and every further byte is ignored until the next start condition.
- R2: An accepted byte is acknowledged by holding the data line low through the ninth clock pulse. The line is released after the falling edge of that pulse.
- R3: A word address inside the register window (0x00 to 0x1F by default) or the SRAM window (0x20 to 0x5F by default) is acknowledged and loaded into the pointer. The pointer, shown on `mem_addr_o`, only changes while the clock line is low.
- R4: A word address outside both windows is not acknowledged, and the pointer keeps its previous value.
- R5: The byte after an accepted word address is acknowledged and written with a single-cycle `mem_we_o` pulse at the pointer address. The pointer then becomes that address plus one.
- R6: A read control byte sent straight after a start returns the byte at the pointer, and the pointer then advances by one.
- R7: A word-address-only write, followed by a repeated start and a read control byte, returns the byte at that address. The pointer ends at that address plus one.
- R8: Read data goes out most significant bit first. The data line changes only while the clock line is low, and each bit, the first included, is valid before the rising clock edge that samples it.
- R9: After the eighth read bit the block releases the data line and drives nothing during the controller's acknowledge clock or after it.
- R10: A start or stop condition inside a byte drops that byte. A stop condition returns the block to idle and no write occurs. A start begins a new control byte.
- R11: After reset the data line is released, `mem_we_o` is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mem_addr_o | output | 8 | Memory address, equal to the pointer |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | One-cycle memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid one clock after the address |

## Verification
The main function is tried with five transaction shapes: a full byte write, a bare current-address read, an address-only write followed by a repeated start and a read, a foreign control code, and transactions cut short by a stop or a start in mid-byte. Comparing the returned bytes after a current-address read and after a random read shows whether the pointer kept its value and then advanced. The foreign code and the out-of-window addresses, 0x60 and 0xFF next to the valid edge 0x5F, separate refusing a byte from ignoring a whole transaction. The cut-short cases show that an incomplete data byte never reaches the memory port.

// File: rtl/i2c_mt_pkg.sv
package i2c_mt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ACK_CW,
        ST_ACK_CR,
        ST_ADDR,
        ST_ACK_AD,
        ST_WDATA,
        ST_ACK_WD,
        ST_TX,
        ST_RACK
    } mt_state_e;

endpackage

// File: rtl/i2c_mt_edges.sv
module i2c_mt_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t d, q;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise_o = scl_i & ~q.scl;
    assign scl_fall_o = ~scl_i & q.scl;
    // data moving while the clock is held high marks a bus condition
    assign start_o    = scl_i & q.scl & q.sda & ~sda_i;
    assign stop_o     = scl_i & q.scl & ~q.sda & sda_i;

endmodule

// File: rtl/i2c_mt_map.sv
module i2c_mt_map #(
    parameter int          AW  = 8,
    parameter int unsigned LO0 = 0,
    parameter int unsigned HI0 = 31,
    parameter int unsigned LO1 = 32,
    parameter int unsigned HI1 = 95
) (
    input  logic [AW-1:0] addr_i,
    output logic          valid_o
);

    localparam int NWIN = 2;
    localparam int unsigned LO_T [NWIN] = '{LO0, LO1};
    localparam int unsigned HI_T [NWIN] = '{HI0, HI1};

    logic [NWIN-1:0] hit;

    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            // unsigned offset wraps high when below the window start
            assign hit[g] = ((32'(addr_i) - LO_T[g]) <= (HI_T[g] - LO_T[g]));
        end
    endgenerate

    assign valid_o = |hit;

endmodule

// File: rtl/i2c_memtarget.sv
module i2c_memtarget
    import i2c_mt_pkg::*;
#(
    parameter logic [6:0]  CTRL_CODE = 7'b1101111,
    parameter int unsigned REG_FIRST = 0,
    parameter int unsigned REG_LAST  = 31,
    parameter int unsigned RAM_FIRST = 32,
    parameter int unsigned RAM_LAST  = 95
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        mt_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              we;
        logic [BYTE_W-1:0] wd;
    } core_t;

    core_t d, q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic addr_ok;

    i2c_mt_edges u_edges (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_mt_map #(
        .AW  (BYTE_W),
        .LO0 (REG_FIRST),
        .HI0 (REG_LAST),
        .LO1 (RAM_FIRST),
        .HI1 (RAM_LAST)
    ) u_map (
        .addr_i  (q.sh),
        .valid_o (addr_ok)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_det) begin
            d.st  = ST_CTRL;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && q.cnt != LAST_BIT) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        if (q.st == ST_CTRL) begin
                            if (q.sh[BYTE_W-1:1] == CTRL_CODE) begin
                                d.oe = 1'b1;
                                d.st = q.sh[0] ? ST_ACK_CR : ST_ACK_CW;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_ADDR) begin
                            if (addr_ok) begin
                                d.oe  = 1'b1;
                                d.ptr = q.sh;
                                d.st  = ST_ACK_AD;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.we = 1'b1;
                            d.wd = q.sh;
                            d.st = ST_ACK_WD;
                        end
                    end
                end
                ST_ACK_CW: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_ADDR;
                    end
                end
                ST_ACK_AD: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WDATA;
                    end
                end
                ST_ACK_WD: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.ptr = q.ptr + 1'b1;
                        d.st  = ST_IDLE;
                    end
                end
                ST_ACK_CR: begin
                    if (scl_fall) begin
                        d.sh  = mem_rdata_i;
                        d.oe  = ~mem_rdata_i[BYTE_W-1];
                        d.ptr = q.ptr + 1'b1;
                        d.cnt = '0;
                        d.st  = ST_TX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.st = ST_IDLE;
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0, oe: 1'b0, we: 1'b0, wd: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign mem_addr_o  = q.ptr;
    assign mem_wdata_o = q.wd;
    assign mem_we_o    = q.we;

endmodule

// File: rtl/i2c_memtarget_chk.sv
module i2c_memtarget_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] mem_addr_o,
    input logic       mem_we_o
);

    p_sda_moves_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    p_we_clock_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !scl_i);

    p_we_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> $stable(mem_addr_o));

    p_ptr_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr_o != $past(mem_addr_o)) |-> !scl_i);

endmodule

bind i2c_memtarget i2c_memtarget_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o)
);

// File: tb/i2c_memtarget_test.sv
module i2c_memtarget_test;

    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe_o;
    logic [7:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic       mem_we_o;
    logic [7:0] mem_rdata_i;
    logic [7:0] mem [256];

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
    } wr_t;
    wr_t exp_q[$];

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe_o;

    i2c_memtarget uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // memory environment with one-clock read latency
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: every write pulse must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected write addr", {24'd0, mem_addr_o}, 32'hFFFF);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk("R5 write addr", {24'd0, mem_addr_o}, {24'd0, e.a});
                chk("R5 write data", {24'd0, mem_wdata_o}, {24'd0, e.d});
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(Q);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; wt(Q);
        m_scl = 1'b1; wt(2 * Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic rbit(output logic b, output logic pre);
        m_sda = 1'b1; wt(Q);
        pre = sda_line;
        m_scl = 1'b1; wt(Q);
        b = sda_line; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic acked);
        logic b, p;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b, p);
        acked = ~b;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] v, output int bad);
        logic b, p;
        bad = 0;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            rbit(b, p);
            if (p !== b) bad++;
            v = {v[6:0], b};
        end
        wbit(nack);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        int         bad;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        wt(5);
        chk("R11 reset sda released", {31'd0, sda_oe_o}, 0);
        chk("R11 reset write enable", {31'd0, mem_we_o}, 0);
        chk("R11 reset pointer", {24'd0, mem_addr_o}, 0);
        rst_n = 1'b1;
        wt(4);

        // byte write 0x05 <- 0xA5
        bus_start();
        wbyte(8'hDE, ack); chk("R1 write control ack", {31'd0, ack}, 1);
        chk("R2 released after ninth clock", {31'd0, sda_oe_o}, 0);
        wbyte(8'h05, ack); chk("R3 address ack", {31'd0, ack}, 1);
        exp_q.push_back('{a: 8'h05, d: 8'hA5});
        wbyte(8'hA5, ack); chk("R5 data ack", {31'd0, ack}, 1);
        chk("R2 data ack released", {31'd0, sda_oe_o}, 0);
        bus_stop();
        chk("R5 pointer after write", {24'd0, mem_addr_o}, 32'h06);

        // current-address read at 0x06
        bus_start();
        wbyte(8'hDF, ack); chk("R1 read control ack", {31'd0, ack}, 1);
        rbyte(1'b1, rd, bad);
        chk("R6 current read data", {24'd0, rd}, {24'd0, mem[6]});
        chk("R8 bits valid before rise", bad, 0);
        chk("R9 released after read", {31'd0, sda_oe_o}, 0);
        bus_stop();
        chk("R6 pointer after current read", {24'd0, mem_addr_o}, 32'h07);

        // random read of 0x05 through a repeated start
        bus_start();
        wbyte(8'hDE, ack);
        wbyte(8'h05, ack); chk("R7 address ack", {31'd0, ack}, 1);
        bus_rstart();
        wbyte(8'hDF, ack); chk("R7 read control ack", {31'd0, ack}, 1);
        rbyte(1'b1, rd, bad);
        chk("R7 random read data", {24'd0, rd}, 32'hA5);
        chk("R8 bits valid before rise", bad, 0);
        bus_stop();
        chk("R7 pointer after random read", {24'd0, mem_addr_o}, 32'h06);

        // out-of-map addresses
        bus_start();
        wbyte(8'hDE, ack);
        wbyte(8'h60, ack); chk("R4 address 0x60 refused", {31'd0, ack}, 0);
        bus_stop();
        chk("R4 pointer kept", {24'd0, mem_addr_o}, 32'h06);
        bus_start();
        wbyte(8'hDE, ack);
        wbyte(8'hFF, ack); chk("R4 address 0xFF refused", {31'd0, ack}, 0);
        bus_stop();
        chk("R4 pointer kept again", {24'd0, mem_addr_o}, 32'h06);

        // last SRAM address is valid
        bus_start();
        wbyte(8'hDE, ack);
        wbyte(8'h5F, ack); chk("R3 edge address 0x5F ack", {31'd0, ack}, 1);
        exp_q.push_back('{a: 8'h5F, d: 8'h3C});
        wbyte(8'h3C, ack);
        bus_stop();
        chk("R5 pointer after edge write", {24'd0, mem_addr_o}, 32'h60);

        // foreign control code: refused, rest ignored
        bus_start();
        wbyte(8'hA0, ack); chk("R1 foreign code refused", {31'd0, ack}, 0);
        wbyte(8'h00, ack); chk("R1 byte ignored after foreign code", {31'd0, ack}, 0);
        wbyte(8'hDE, ack); chk("R1 own code ignored without start", {31'd0, ack}, 0);
        bus_stop();
        chk("R1 pointer untouched", {24'd0, mem_addr_o}, 32'h60);

        // stop inside a data byte: no write
        bus_start();
        wbyte(8'hDE, ack);
        wbyte(8'h10, ack); chk("R3 address 0x10 ack", {31'd0, ack}, 1);
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        bus_stop();
        wt(4);
        chk("R10 pointer after aborted write", {24'd0, mem_addr_o}, 32'h10);
        chk("R10 aborted byte not stored", {24'd0, mem[16]}, 32'(16 * 7 + 3));

        // start inside a control byte: new control byte begins
        bus_start();
        wbit(1'b1); wbit(1'b1); wbit(1'b0);
        bus_rstart();
        wbyte(8'hDF, ack); chk("R10 control after mid-byte start", {31'd0, ack}, 1);
        rbyte(1'b1, rd, bad);
        chk("R10 read after mid-byte start", {24'd0, rd}, 32'(16 * 7 + 3));
        bus_stop();
        chk("R6 pointer advanced", {24'd0, mem_addr_o}, 32'h11);

        wt(8);
        chk("R5 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule